// File: doc/BRIEF.md
# Folding Branch-Target Buffer

This block sits in the fetch stage and is consulted every cycle with the address being fetched. It is a direct-mapped table. Each line records a branch address tag, the address that branch is predicted to jump to, and a copy of the instruction stored at that destination. A line also holds a flag that says whether the branch always jumps. When a lookup finds a conditional branch, the block only steers the next fetch address to the recorded destination. When it finds an unconditional branch, the block also hands the pipeline the recorded destination instruction in place of the branch word from the instruction cache. The branch then disappears from the instruction stream and costs no cycles.

Branch resolution reports every resolved branch on the update port. The report gives the branch address, the real outcome, whether fetch predicted it taken, and the destination address and instruction. A taken branch is written into the table. A branch that did not jump removes its own line. Each disagreement between prediction and outcome is flagged in the same cycle, together with a two-cycle penalty and the address to restart fetch from.

Top module: `btb_fold`

## Requirements
- R1: Reset invalidates every line, so the first lookups after reset miss.
- R2: The line is selected by fetch address bits [5:2] and hits only if it is valid and its stored tag equals fetch address bits [31:6]. An address that shares the index but has a different tag misses.
- R3: On a miss, the next fetch address is the fetch address plus 4 and the delivered instruction is the cache word.
- R4: On a hit to a conditional line, the next fetch address is the stored destination and the delivered instruction is the cache word.
- R5: On a hit to an unconditional line, the delivered instruction is the stored destination instruction and the next fetch address is the stored destination plus 4.
- R6: A resolved taken branch writes its line (tag, destination, destination instruction, unconditional flag) at the clock edge, and a lookup of that address in the next cycle hits.
- R7: A resolved not-taken branch clears the line only when that line holds the same branch. A not-taken report for an aliasing address leaves the line intact.
- R8: If a branch was predicted taken but is not taken, mispredict is 1, penalty is 2, and the restart address is the branch address plus 4.
- R9: If a branch is taken but was not predicted taken, mispredict is 1, penalty is 2, the restart address is the reported destination, and the branch is written into the table.
- R10: When an update and a lookup hit the same line in one cycle, the lookup returns the contents from before the update.
- R11: When the prediction agrees with the outcome, mispredict is 0 and penalty is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | 32 | Address being fetched this cycle |
| cache_inst | input | 32 | Instruction word returned by the instruction cache |
| pred_hit | output | 1 | Lookup found a valid matching line |
| pred_fold | output | 1 | Hit line is unconditional; branch is folded |
| next_pc | output | 32 | Address to fetch in the next cycle |
| fetch_inst | output | 32 | Instruction passed down the pipeline |
| upd_valid | input | 1 | A resolved branch is reported this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome (1 = jumped) |
| upd_pred_taken | input | 1 | Fetch predicted this branch taken |
| upd_target | input | 32 | Resolved destination address |
| upd_target_inst | input | 32 | Instruction found at the destination |
| upd_uncond | input | 1 | Branch always jumps |
| mispredict | output | 1 | Prediction disagreed with the outcome |
| penalty | output | 2 | Cycles lost on this report (0 or 2) |
| redirect_pc | output | 32 | Restart address after a misprediction |

## Verification
The lookup is tried with an empty line, with a conditional line, with an unconditional line, and with an address that aliases a stored branch. These four cases separate the miss, redirect-only, fold and tag-mismatch paths. Updates are tried with each combination of predicted and actual outcome. This shows the penalty appears only on disagreement and that the restart address follows the outcome. Lookups are made in the same cycle as an update to the same line and again one cycle later. This separates the old contents from the newly written contents. A not-taken report for an aliasing address shows that only a matching line is cleared.

// File: rtl/btb_fold.sv
module btb_fold #(
  parameter int PC_W     = 32,
  parameter int INST_W   = 32,
  parameter int IDX_W    = 4,
  parameter int MISS_PEN = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PC_W-1:0]      fetch_pc,
  input  logic [INST_W-1:0]    cache_inst,
  output logic                 pred_hit,
  output logic                 pred_fold,
  output logic [PC_W-1:0]      next_pc,
  output logic [INST_W-1:0]    fetch_inst,
  input  logic                 upd_valid,
  input  logic [PC_W-1:0]      upd_pc,
  input  logic                 upd_taken,
  input  logic                 upd_pred_taken,
  input  logic [PC_W-1:0]      upd_target,
  input  logic [INST_W-1:0]    upd_target_inst,
  input  logic                 upd_uncond,
  output logic                 mispredict,
  output logic [1:0]           penalty,
  output logic [PC_W-1:0]      redirect_pc
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = PC_W - IDX_W - 2;
  localparam logic [PC_W-1:0] STEP = PC_W'(4);

  logic [ENTRIES-1:0] vld_q;
  logic [ENTRIES-1:0] unc_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [PC_W-1:0]    tgt_q [ENTRIES];
  logic [INST_W-1:0]  ins_q [ENTRIES];

  logic [IDX_W-1:0] f_idx, u_idx;
  logic [TAG_W-1:0] f_tag, u_tag;
  logic             u_match;
  logic             unused_lsb;

  assign f_idx = fetch_pc[IDX_W+1:2];
  assign f_tag = fetch_pc[PC_W-1:IDX_W+2];
  assign u_idx = upd_pc[IDX_W+1:2];
  assign u_tag = upd_pc[PC_W-1:IDX_W+2];
  assign unused_lsb = ^{fetch_pc[1:0], upd_pc[1:0]};

  assign pred_hit   = vld_q[f_idx] && (tag_q[f_idx] == f_tag);
  assign pred_fold  = pred_hit && unc_q[f_idx];
  assign fetch_inst = pred_fold ? ins_q[f_idx] : cache_inst;
  assign next_pc    = pred_fold ? tgt_q[f_idx] + STEP :
                      pred_hit  ? tgt_q[f_idx] : fetch_pc + STEP;

  assign u_match     = vld_q[u_idx] && (tag_q[u_idx] == u_tag);
  assign mispredict  = upd_valid && (upd_taken != upd_pred_taken);
  assign penalty     = mispredict ? 2'(MISS_PEN) : 2'd0;
  assign redirect_pc = upd_taken ? upd_target : upd_pc + STEP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (upd_valid) begin
      if (upd_taken)    vld_q[u_idx] <= 1'b1;
      else if (u_match) vld_q[u_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (upd_valid && upd_taken) begin
      tag_q[u_idx] <= u_tag;
      tgt_q[u_idx] <= upd_target;
      ins_q[u_idx] <= upd_target_inst;
      unc_q[u_idx] <= upd_uncond;
    end
  end

  a_r1_reset_empty: assert property (@(posedge clk)
    !rst_n |=> !pred_hit);

  a_r3_miss_sequential: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_hit |-> (fetch_inst == cache_inst) && (next_pc == fetch_pc + STEP));

  a_r6_alloc_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken) |=> (fetch_pc != $past(upd_pc)) || pred_hit);

  a_r7_clear_on_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken) |=> (fetch_pc != $past(upd_pc)) || !pred_hit);

  a_r8_penalty_value: assert property (@(posedge clk) disable iff (!rst_n)
    mispredict |-> penalty == 2'(MISS_PEN));

  a_r8_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (mispredict && !upd_taken) |-> redirect_pc == upd_pc + STEP);

  a_r11_no_penalty: assert property (@(posedge clk) disable iff (!rst_n)
    !mispredict |-> penalty == 2'd0);
endmodule

// File: tb/sim_btb_fold.sv
module sim_btb_fold;
  localparam int CLK_P = 10;
  localparam int NV = 12;

  typedef struct packed {
    logic [7:0]  req;
    logic        uv;
    logic [31:0] upc;
    logic        ut;
    logic        up;
    logic [31:0] utgt;
    logic [31:0] uins;
    logic        uunc;
    logic [31:0] fpc;
    logic [31:0] ci;
    logic        ehit;
    logic        efold;
    logic [31:0] enpc;
    logic [31:0] eins;
    logic        emis;
    logic [31:0] ered;
  } vec_t;

  // A=0x100 (line 0), alias 0x140 (line 0), B=0x204 (line 1), C=0x308 (line 2)
  localparam vec_t TBL [NV] = '{
    // R3 empty line
    '{8'd3, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0, 32'h100, 32'h11, 1'b0, 1'b0, 32'h104, 32'h11, 1'b0, 32'h0},
    // R9 R10 taken, unpredicted; lookup sees old line
    '{8'd9, 1'b1, 32'h100, 1'b1, 1'b0, 32'h800, 32'hAA, 1'b0, 32'h100, 32'h12, 1'b0, 1'b0, 32'h104, 32'h12, 1'b1, 32'h800},
    // R4 R6 conditional hit
    '{8'd4, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0, 32'h100, 32'h13, 1'b1, 1'b0, 32'h800, 32'h13, 1'b0, 32'h0},
    // R2 alias misses; B allocated unconditional
    '{8'd2, 1'b1, 32'h204, 1'b1, 1'b0, 32'h900, 32'hBB, 1'b1, 32'h140, 32'h14, 1'b0, 1'b0, 32'h144, 32'h14, 1'b1, 32'h900},
    // R5 fold
    '{8'd5, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0, 32'h204, 32'h15, 1'b1, 1'b1, 32'h904, 32'hBB, 1'b0, 32'h0},
    // R11 correct prediction
    '{8'd11, 1'b1, 32'h100, 1'b1, 1'b1, 32'h800, 32'hAA, 1'b0, 32'h204, 32'h16, 1'b1, 1'b1, 32'h904, 32'hBB, 1'b0, 32'h0},
    // R7 not-taken alias report
    '{8'd7, 1'b1, 32'h140, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0, 32'h100, 32'h17, 1'b1, 1'b0, 32'h800, 32'h17, 1'b0, 32'h0},
    // R7 line kept
    '{8'd7, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0, 32'h100, 32'h18, 1'b1, 1'b0, 32'h800, 32'h18, 1'b0, 32'h0},
    // R8 R10 predicted taken, not taken
    '{8'd8, 1'b1, 32'h100, 1'b0, 1'b1, 32'h0, 32'h0, 1'b0, 32'h100, 32'h19, 1'b1, 1'b0, 32'h800, 32'h19, 1'b1, 32'h104},
    // R7 line cleared
    '{8'd7, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0, 32'h100, 32'h1A, 1'b0, 1'b0, 32'h104, 32'h1A, 1'b0, 32'h0},
    // R3 other line empty
    '{8'd3, 1'b1, 32'h204, 1'b1, 1'b1, 32'h900, 32'hBB, 1'b1, 32'h308, 32'h1B, 1'b0, 1'b0, 32'h30C, 32'h1B, 1'b0, 32'h0},
    // R5 fold still present
    '{8'd5, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0, 32'h204, 32'h1C, 1'b1, 1'b1, 32'h904, 32'hBB, 1'b0, 32'h0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] fetch_pc = '0, cache_inst = '0, upd_pc = '0, upd_target = '0, upd_target_inst = '0;
  logic upd_valid = 1'b0, upd_taken = 1'b0, upd_pred_taken = 1'b0, upd_uncond = 1'b0;
  logic pred_hit, pred_fold, mispredict;
  logic [31:0] next_pc, fetch_inst, redirect_pc;
  logic [1:0] penalty;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  btb_fold u0 (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .cache_inst(cache_inst),
    .pred_hit(pred_hit), .pred_fold(pred_fold), .next_pc(next_pc), .fetch_inst(fetch_inst),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_pred_taken(upd_pred_taken), .upd_target(upd_target),
    .upd_target_inst(upd_target_inst), .upd_uncond(upd_uncond),
    .mispredict(mispredict), .penalty(penalty), .redirect_pc(redirect_pc)
  );

  task automatic chk(input int rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic idle_fetch(input logic [31:0] pc, input logic [31:0] ci);
    upd_valid = 1'b0; fetch_pc = pc; cache_inst = ci;
  endtask

  initial begin
    #(CLK_P * 5000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog actual=%h expected=%h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state, lookups miss
    idle_fetch(32'h100, 32'h55);
    repeat (2) @(negedge clk);
    #(CLK_P/4);
    chk(1, "hit in reset", 32'(pred_hit), 32'h0);
    @(negedge clk) rst_n = 1'b1;
    #(CLK_P/4);
    chk(1, "hit after reset", 32'(pred_hit), 32'h0);
    chk(1, "inst after reset", fetch_inst, 32'h55);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      upd_valid = TBL[i].uv; upd_pc = TBL[i].upc; upd_taken = TBL[i].ut;
      upd_pred_taken = TBL[i].up; upd_target = TBL[i].utgt;
      upd_target_inst = TBL[i].uins; upd_uncond = TBL[i].uunc;
      fetch_pc = TBL[i].fpc; cache_inst = TBL[i].ci;
      #(CLK_P/4);
      chk(int'(TBL[i].req), "hit", 32'(pred_hit), 32'(TBL[i].ehit));
      chk(int'(TBL[i].req), "fold", 32'(pred_fold), 32'(TBL[i].efold));
      chk(int'(TBL[i].req), "next_pc", next_pc, TBL[i].enpc);
      chk(int'(TBL[i].req), "inst", fetch_inst, TBL[i].eins);
      chk(int'(TBL[i].req), "mispredict", 32'(mispredict), 32'(TBL[i].emis));
      chk(int'(TBL[i].req), "penalty", 32'(penalty), TBL[i].emis ? 32'd2 : 32'd0);
      if (TBL[i].emis) chk(int'(TBL[i].req), "redirect", redirect_pc, TBL[i].ered);
    end

    // R6: unconditional allocate at C, visible next cycle with fold
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = 32'h308; upd_taken = 1'b1; upd_pred_taken = 1'b0;
    upd_target = 32'hA00; upd_target_inst = 32'hCC; upd_uncond = 1'b1;
    fetch_pc = 32'h308; cache_inst = 32'h33;
    #(CLK_P/4);
    chk(10, "same-cycle old inst", fetch_inst, 32'h33);
    @(negedge clk) idle_fetch(32'h308, 32'h34);
    #(CLK_P/4);
    chk(6, "alloc fold inst", fetch_inst, 32'hCC);
    chk(6, "alloc next_pc", next_pc, 32'hA04);

    // R1: reset mid-run clears lines
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1; idle_fetch(32'h204, 32'h44);
    #(CLK_P/4);
    chk(1, "hit after mid reset", 32'(pred_hit), 32'h0);
    chk(1, "next after mid reset", next_pc, 32'h208);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule